// File: doc/BRIEF.md
# Carrier Control and Interrupt Status Registers

This block holds the small register set that a module carrier card exposes in its local control window. A byte-wide control register selects the bus clock rate of each of four module slots. The same register arms a sticky bus-timeout flag and enables the timeout responder in the access controller. It also gates the card's interrupt and lets software force an interrupt for debug.

A read-only pending register shows the eight module interrupt lines, two per slot, after they cross into the register clock domain. A read-only status register shows the timeout flag and the level of the merged interrupt output. The host uses a plain register port: address, write strobe, write data, and combinational read data.

The merged output, `lint_o`, is active high. It is raised when interrupts are enabled and at least one source is active: a pending module line, the timeout flag, or the software force bit. With interrupts disabled, every source keeps its state and stays readable, but the output stays low.

Top module: `ipc_ctl_status`

## Requirements
- R1: The control register sits at window offset 0x500. It resets to 0x00, reads back the last byte written to it, and a write takes effect at the clock edge that samples the strobe.
- R2: Control bits 3..0 drive `slot_clk_sel_o[3:0]` (bit n for slot n, 1 = fast clock). Control bit 5 drives `tmo_en_o`.
- R3: The read-only pending register at offset 0x600 returns the module lines after a two-flop synchronizer. Bit 0 is slot A line 0, bit 1 is slot A line 1, and so on up to bit 7, slot D line 1. A change on an input appears two clock edges later.
- R4: Writes to offsets 0x600, 0x700 or any other offset leave the control register unchanged.
- R5: While control bit 4 (arm) is 0, the timeout flag is held at 0 and timeout events are ignored.
- R6: While arm is 1, a timeout event sets the flag at the next edge. The flag then stays set until the arm bit is 0 at an edge.
- R7: The read-only status register at offset 0x700 returns the timeout flag in bit 6 and the level of `lint_o` in bit 7. Its other bits read 0.
- R8: With control bit 6 (interrupt enable) at 1, `lint_o` is high exactly when a pending bit is set, the timeout flag is set, or control bit 7 (force) is 1.
- R9: With interrupt enable at 0, `lint_o` is low while the pending bits and the timeout flag remain visible through their registers.
- R10: Every offset other than 0x500, 0x600 and 0x700 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr | input | 11 | Byte offset within the local control window |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| mod_irq_i | input | 8 | Module interrupt lines, asynchronous, active high |
| tmo_evt_i | input | 1 | Bus-timeout event pulse from the access controller |
| slot_clk_sel_o | output | 4 | Per-slot clock-rate select |
| tmo_en_o | output | 1 | Timeout responder enable to the access controller |
| lint_o | output | 1 | Merged local interrupt, active high |

## Verification
The bench targets the arm bit's double role. It pulses a timeout while arm is low; a design that latched that pulse would show a spurious flag later. It clears arm while a flag is set; a flag that survived the clear, or returned when arm was raised again, would show up in the status read.

It holds module lines active with interrupt enable low. A leaky gate would raise `lint_o`, and a design that blocked the sources themselves would lose the pending bits. Writes aimed at the read-only and unused offsets catch a loose address decode that corrupts the control register. Line changes are checked at the exact second edge, so a missing or extra synchronizer stage shows up as a one-cycle skew.

// File: rtl/ipc_ctl_pkg.sv
package ipc_ctl_pkg;
  localparam int WIN_AW = 11;
  localparam int REG_W  = 8;

  localparam logic [WIN_AW-1:0] OFS_CTRL = 11'h500;
  localparam logic [WIN_AW-1:0] OFS_PEND = 11'h600;
  localparam logic [WIN_AW-1:0] OFS_STAT = 11'h700;

  // control register bit positions (clock selects occupy the low bits)
  localparam int CB_ARM = 4;
  localparam int CB_TEN = 5;
  localparam int CB_IEN = 6;
  localparam int CB_FRC = 7;

  // status register bit positions
  localparam int SB_FLAG = 6;
  localparam int SB_LINT = 7;
endpackage

// File: rtl/ipc_rst_sync.sv
module ipc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/ipc_sync.sv
module ipc_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q[0] <= '0;
    else        stg_q[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= '0;
      else        stg_q[s] <= stg_q[s-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/ipc_tmo_flag.sv
module ipc_tmo_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic evt,
  output logic flag_q
);
  logic flag_d;

  always_comb begin
    if (arm) flag_d = flag_q | evt;
    else     flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end
endmodule

// File: rtl/ipc_ctl_status.sv
module ipc_ctl_status
  import ipc_ctl_pkg::*;
#(
  parameter int NSLOT       = 4,
  parameter int LINES_SLOT  = 2,
  parameter int ADDR_W      = WIN_AW,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic                        reg_we,
  input  logic [REG_W-1:0]            reg_wdata,
  output logic [REG_W-1:0]            reg_rdata,
  input  logic [NSLOT*LINES_SLOT-1:0] mod_irq_i,
  input  logic                        tmo_evt_i,
  output logic [NSLOT-1:0]            slot_clk_sel_o,
  output logic                        tmo_en_o,
  output logic                        lint_o
);
  localparam int NLINE = NSLOT * LINES_SLOT;

  logic             rst_s_n;
  logic [REG_W-1:0] ctrl_q;
  logic [REG_W-1:0] ctrl_d;
  logic             ctrl_we;
  logic [NLINE-1:0] pend;
  logic             flag_q;

  ipc_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_s_n)
  );

  ipc_sync #(.W(NLINE), .STAGES(SYNC_STAGES)) u_irq_sync (
    .clk   (clk),
    .rst_n (rst_s_n),
    .d     (mod_irq_i),
    .q     (pend)
  );

  // control register: clock enable is the decoded write strobe
  always_comb begin
    ctrl_we = reg_we && (reg_addr == ADDR_W'(OFS_CTRL));
    ctrl_d  = ctrl_we ? reg_wdata : ctrl_q;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) ctrl_q <= '0;
    else          ctrl_q <= ctrl_d;
  end

  ipc_tmo_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .arm    (ctrl_q[CB_ARM]),
    .evt    (tmo_evt_i),
    .flag_q (flag_q)
  );

  always_comb begin
    lint_o = ctrl_q[CB_IEN] & ((|pend) | flag_q | ctrl_q[CB_FRC]);
  end

  assign slot_clk_sel_o = ctrl_q[NSLOT-1:0];
  assign tmo_en_o       = ctrl_q[CB_TEN];

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(OFS_CTRL)) begin
      reg_rdata = ctrl_q;
    end else if (reg_addr == ADDR_W'(OFS_PEND)) begin
      reg_rdata[NLINE-1:0] = pend;
    end else if (reg_addr == ADDR_W'(OFS_STAT)) begin
      reg_rdata[SB_FLAG] = flag_q;
      reg_rdata[SB_LINT] = lint_o;
    end
  end
endmodule

// File: rtl/ipc_ctl_status_chk.sv
module ipc_ctl_status_chk
  import ipc_ctl_pkg::*;
#(
  parameter int ADDR_W = WIN_AW,
  parameter int NSLOT  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_we,
  input logic [REG_W-1:0]  reg_wdata,
  input logic [REG_W-1:0]  reg_rdata,
  input logic [REG_W-1:0]  ctrl_q,
  input logic              flag_q,
  input logic              tmo_evt_i,
  input logic [NSLOT-1:0]  slot_clk_sel_o,
  input logic              tmo_en_o,
  input logic              lint_o
);
  logic wr_ctrl;
  logic known;
  assign wr_ctrl = reg_we && (reg_addr == ADDR_W'(OFS_CTRL));
  assign known   = (reg_addr == ADDR_W'(OFS_CTRL)) || (reg_addr == ADDR_W'(OFS_PEND)) ||
                   (reg_addr == ADDR_W'(OFS_STAT));

  // R1
  ctrl_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> ctrl_q == $past(reg_wdata));

  // R2
  ctrl_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (slot_clk_sel_o == $past(reg_wdata[NSLOT-1:0])) && (tmo_en_o == $past(reg_wdata[CB_TEN])));

  // R4
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(ctrl_q));

  // R5
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[CB_ARM] |=> !flag_q);

  // R6
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[CB_ARM] && tmo_evt_i |=> flag_q);

  // R6
  flag_stick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[CB_ARM] && flag_q |=> flag_q);

  // R8
  force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[CB_IEN] && ctrl_q[CB_FRC] |-> lint_o);

  // R9
  block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[CB_IEN] |-> !lint_o);

  // R10
  unused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !known |-> reg_rdata == '0);
endmodule

bind ipc_ctl_status ipc_ctl_status_chk #(.ADDR_W(ADDR_W), .NSLOT(NSLOT)) u_chk (
  .clk            (clk),
  .rst_n          (rst_s_n),
  .reg_addr       (reg_addr),
  .reg_we         (reg_we),
  .reg_wdata      (reg_wdata),
  .reg_rdata      (reg_rdata),
  .ctrl_q         (ctrl_q),
  .flag_q         (flag_q),
  .tmo_evt_i      (tmo_evt_i),
  .slot_clk_sel_o (slot_clk_sel_o),
  .tmo_en_o       (tmo_en_o),
  .lint_o         (lint_o)
);

// File: tb/ipc_ctl_status_tb.sv
module ipc_ctl_status_tb;
  logic        clk;
  logic        rst_n;
  logic [10:0] reg_addr;
  logic        reg_we;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic [7:0]  mod_irq;
  logic        tmo_evt;
  logic [3:0]  slot_clk_sel;
  logic        tmo_en;
  logic        lint;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // bench model state
  logic [7:0] m_ctrl, m_s1, m_s2;
  logic       m_flag;

  ipc_ctl_status u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .reg_addr       (reg_addr),
    .reg_we         (reg_we),
    .reg_wdata      (reg_wdata),
    .reg_rdata      (reg_rdata),
    .mod_irq_i      (mod_irq),
    .tmo_evt_i      (tmo_evt),
    .slot_clk_sel_o (slot_clk_sel),
    .tmo_en_o       (tmo_en),
    .lint_o         (lint)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic exp_lint();
    return m_ctrl[6] & ((|m_s2) | m_flag | m_ctrl[7]);
  endfunction

  function automatic logic [7:0] exp_read(input logic [10:0] a);
    case (a)
      11'h500: return m_ctrl;
      11'h600: return m_s2;
      11'h700: return {exp_lint(), m_flag, 6'b0};
      default: return 8'h00;
    endcase
  endfunction

  function automatic string rtag(input logic [10:0] a);
    case (a)
      11'h500: return "R1 R4 control read";
      11'h600: return "R3 pending read";
      11'h700: return "R7 R5 R6 status read";
      default: return "R10 unused read";
    endcase
  endfunction

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [10:0] a, input logic we, input logic [7:0] wd,
                      input logic [7:0] irq, input logic ev);
    @(negedge clk);
    reg_addr = a; reg_we = we; reg_wdata = wd; mod_irq = irq; tmo_evt = ev;
    #2;
    check(reg_rdata, exp_read(a), rtag(a));
    check({4'b0, slot_clk_sel}, {4'b0, m_ctrl[3:0]}, "R2 clock selects");
    check({7'b0, tmo_en}, {7'b0, m_ctrl[5]}, "R2 timeout enable");
    check({7'b0, lint}, {7'b0, exp_lint()}, m_ctrl[6] ? "R8 merged interrupt" : "R9 blocked interrupt");
    @(posedge clk);
    #1;
    m_flag = m_ctrl[4] ? (m_flag | ev) : 1'b0;
    m_s2 = m_s1;
    m_s1 = irq;
    if (we && a == 11'h500) m_ctrl = wd;
  endtask

  task automatic rd(input logic [10:0] a, input logic [7:0] irq);
    step(a, 1'b0, 8'h00, irq, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] irq_r;
    void'($urandom(32'd2718));
    rst_n = 1'b0; reg_addr = '0; reg_we = 0; reg_wdata = 0; mod_irq = 0; tmo_evt = 0;
    m_ctrl = 0; m_s1 = 0; m_s2 = 0; m_flag = 0;
    repeat (4) @(posedge clk);
    #3 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    rd(11'h500, 8'h00);
    rd(11'h600, 8'h00);
    rd(11'h700, 8'h00);
    // R1 R2 write and read back
    step(11'h500, 1, 8'h2F, 8'h00, 0);
    rd(11'h500, 8'h00);
    // R4 writes to read-only and unused offsets
    step(11'h600, 1, 8'hFF, 8'h00, 0);
    step(11'h700, 1, 8'hFF, 8'h00, 0);
    step(11'h501, 1, 8'hD0, 8'h00, 0);
    rd(11'h500, 8'h00);
    // R5 event while disarmed is ignored
    step(11'h500, 1, 8'h00, 8'h00, 0);
    step(11'h700, 0, 8'h00, 8'h00, 1);
    rd(11'h700, 8'h00);
    // R6 arm, event, sticky
    step(11'h500, 1, 8'h10, 8'h00, 0);
    step(11'h700, 0, 8'h00, 8'h00, 1);
    rd(11'h700, 8'h00);
    rd(11'h700, 8'h00);
    // R8 enable with flag only
    step(11'h500, 1, 8'h50, 8'h00, 0);
    rd(11'h700, 8'h00);
    // R6 disarm clears, re-arm does not restore
    step(11'h500, 1, 8'h40, 8'h00, 0);
    rd(11'h700, 8'h00);
    step(11'h500, 1, 8'h50, 8'h00, 0);
    rd(11'h700, 8'h00);
    // R9 pending with enable low
    step(11'h500, 1, 8'h00, 8'h81, 0);
    rd(11'h600, 8'h81);
    rd(11'h600, 8'h81);
    rd(11'h700, 8'h81);
    // R3 per-line order, walking one
    for (int i = 0; i < 8; i++) begin
      rd(11'h600, 8'h01 << i);
      rd(11'h600, 8'h01 << i);
    end
    // R8 enable and release lines
    step(11'h500, 1, 8'h40, 8'h24, 0);
    rd(11'h700, 8'h00);
    rd(11'h700, 8'h00);
    rd(11'h700, 8'h00);
    // R8 software force
    step(11'h500, 1, 8'hC0, 8'h00, 0);
    rd(11'h700, 8'h00);
    step(11'h500, 1, 8'h80, 8'h00, 0);
    rd(11'h700, 8'h00);
    // R10 unused offsets
    rd(11'h000, 8'h00);
    rd(11'h4FF, 8'h00);
    rd(11'h701, 8'h00);
    rd(11'h7FF, 8'h00);

    irq_r = 8'h00;
    for (int n = 0; n < 4000; n++) begin
      logic [10:0] a;
      logic        we;
      case ($urandom % 5)
        0: a = 11'h500;
        1: a = 11'h600;
        2: a = 11'h700;
        3: a = 11'h500;
        default: a = 11'($urandom);
      endcase
      we = ($urandom % 4) == 0;
      if (($urandom % 6) == 0) irq_r = 8'($urandom) & 8'($urandom);
      step(a, we, 8'($urandom), irq_r, ($urandom % 12) == 0);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule